// File: doc/BRIEF.md
# Field-Enabled BCD Alarm and Interrupt Merger

This block watches the running BCD time of day (seconds, minutes, hours with an AM/PM bit, and day of the week) and compares it with a stored alarm. Each of the four alarm fields has its own enable bit. A field whose enable is clear plays no part in the comparison. This lets one comparator produce a single weekly alarm, a daily alarm, or a periodic alarm such as one every minute when only the seconds field is enabled. The time-counting logic outside this block drives the current values and pulses `tick` in each cycle where they hold a freshly advanced time. The comparison is evaluated only on those ticks.

A two-state matcher (states MATCH_ARMED and MATCH_HELD) makes sure a continuous match raises the alarm only once. The transition FIRE (MATCH_ARMED to MATCH_HELD) happens on a tick that sees a match and produces the alarm event. The transition RELEASE (MATCH_HELD to MATCH_ARMED) happens on a tick that sees no match. The transition REARM (either state to MATCH_ARMED) happens on any write to an alarm word, and a tick in that same cycle is ignored.

Three event sources (update acknowledge, alarm, second event) set sticky status flags. Flags are cleared by a write-one-to-clear command. Each source has a mask bit that is set through an enable strobe and cleared through a disable strobe. The single active-high interrupt is raised when any flag is set together with its mask bit.

Top module: `rtc_alarm_irq`

## Requirements
- R1: After reset, `status`, `irq_mask` and `irq` are 0, `alarm_time_rd` reads 0, and `alarm_day_rd` reads 0x00000100 (day 1, disabled).
- R2: The time alarm word holds the second in bits 6:0 with its enable at bit 7, the minute in bits 14:8 with its enable at bit 15, the hour in bits 21:16, AM/PM at bit 22 and the hour enable at bit 23. The day alarm word holds the day in bits 10:8 with its enable at bit 15. All other bits read back as 0.
- R3: On a cycle with `tick` high, the alarm matches when every enabled field equals the current value. The hour field compares both the hour value and the AM/PM bit.
- R4: Disabled fields are ignored, so with only the seconds field enabled the alarm fires once per minute.
- R5: With no field enabled the alarm never matches.
- R6: The alarm flag is raised only on the tick where the match first becomes true. While the match persists across ticks it is not raised again. A tick without a match re-arms the matcher.
- R7: Writing either alarm word re-arms the matcher, so a match that was already held fires again on the next matching tick.
- R8: `status` bit 0 is update acknowledge, bit 1 is alarm and bit 2 is second event. Each flag is sticky. A status-clear write with a 1 in a bit clears that flag, and a 0 leaves it unchanged.
- R9: When a flag's event and its clear arrive in the same cycle, the flag ends up set.
- R10: An enable write sets the mask bits written as 1, and a disable write clears them. Zero bits have no effect. If both strobes name the same bit in one cycle, the bit ends up cleared.
- R11: `irq` is high exactly when some status flag and its mask bit are both set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Current time is valid and newly advanced |
| cur_sec | input | 7 | Current second, BCD |
| cur_min | input | 7 | Current minute, BCD |
| cur_hour | input | 6 | Current hour, BCD |
| cur_pm | input | 1 | Current AM/PM bit (1 = PM) |
| cur_day | input | 3 | Current day of week |
| upd_ack_evt | input | 1 | Update acknowledge event pulse |
| sec_evt | input | 1 | Second event pulse |
| wr_alarm_time | input | 1 | Write strobe for the time alarm word |
| wr_alarm_day | input | 1 | Write strobe for the day alarm word |
| wr_status_clr | input | 1 | Write strobe for the status clear command |
| wr_irq_en | input | 1 | Write strobe for the mask enable command |
| wr_irq_dis | input | 1 | Write strobe for the mask disable command |
| wdata | input | 32 | Write data for all strobes |
| status | output | 3 | Sticky flags {second, alarm, ack} |
| irq_mask | output | 3 | Interrupt mask, same bit order as status |
| irq | output | 1 | Merged interrupt, active high |
| alarm_time_rd | output | 32 | Readback of the time alarm word |
| alarm_day_rd | output | 32 | Readback of the day alarm word |

## Verification
The assertions check, on every cycle, the relations that hold between port values one edge apart. The alarm flag rises only after a tick and falls only after a clear write that names it. A clear of the acknowledge flag takes effect when no event competes with it. A second event always leaves its flag set, a disable write always leaves the mask bit clear, and no interrupt is raised while the mask is empty.

Only the directed scenarios can show the following:
- which field combinations and AM/PM values count as a match;
- the once-per-minute cadence with only seconds enabled;
- the suppression of a held match, and re-arming by a mismatch tick or by an alarm write;
- the readback layout of both alarm words.

// File: rtl/rtc_alarm_pkg.sv
package rtc_alarm_pkg;
    localparam int SEC_W  = 7;
    localparam int MIN_W  = 7;
    localparam int HOUR_W = 6;
    localparam int DAY_W  = 3;
    localparam int NSRC   = 3;
    localparam int DATA_W = 32;

    localparam int SRC_ACK = 0;
    localparam int SRC_ALM = 1;
    localparam int SRC_SEC = 2;

    localparam int TWORD_W  = SEC_W + MIN_W + HOUR_W + 4;
    localparam int DAY_LSB  = 8;
    localparam int DAY_EN_B = 15;

    typedef enum logic {MATCH_ARMED, MATCH_HELD} match_st_e;

    typedef struct packed {
        logic              hour_en;
        logic              pm;
        logic [HOUR_W-1:0] hour;
        logic              min_en;
        logic [MIN_W-1:0]  min;
        logic              sec_en;
        logic [SEC_W-1:0]  sec;
    } talarm_t;

    typedef struct packed {
        logic             day_en;
        logic [DAY_W-1:0] day;
    } dalarm_t;
endpackage

// File: rtl/alarm_regs.sv
module alarm_regs
    import rtc_alarm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_time,
    input  logic              wr_day,
    input  logic [DATA_W-1:0] wdata,
    output talarm_t           ta,
    output dalarm_t           da
);
    logic unused_hi;
    assign unused_hi = ^{wdata[DATA_W-1:TWORD_W]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ta <= '0;
            da <= '{day_en: 1'b0, day: DAY_W'(1)};
        end else begin
            if (wr_time) ta <= talarm_t'(wdata[TWORD_W-1:0]);
            if (wr_day)  da <= '{day_en: wdata[DAY_EN_B], day: wdata[DAY_LSB +: DAY_W]};
        end
    end
endmodule

// File: rtl/alarm_match.sv
module alarm_match
    import rtc_alarm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              rearm,
    input  logic [SEC_W-1:0]  cur_sec,
    input  logic [MIN_W-1:0]  cur_min,
    input  logic [HOUR_W-1:0] cur_hour,
    input  logic              cur_pm,
    input  logic [DAY_W-1:0]  cur_day,
    input  talarm_t           ta,
    input  dalarm_t           da,
    output logic              alarm_evt
);
    match_st_e st, st_n;
    logic any_en, match;

    always_comb begin
        any_en = ta.sec_en | ta.min_en | ta.hour_en | da.day_en;
        match  = any_en
               & (!ta.sec_en  | (ta.sec == cur_sec))
               & (!ta.min_en  | (ta.min == cur_min))
               & (!ta.hour_en | ((ta.hour == cur_hour) && (ta.pm == cur_pm)))
               & (!da.day_en  | (da.day == cur_day));
    end

    always_comb begin
        st_n = st;
        unique case (st)
            MATCH_ARMED: if (!rearm && tick && match)  st_n = MATCH_HELD;   // FIRE
            MATCH_HELD:  if (rearm)                    st_n = MATCH_ARMED;  // REARM
                         else if (tick && !match)      st_n = MATCH_ARMED;  // RELEASE
            default:                                   st_n = MATCH_ARMED;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= MATCH_ARMED;
        else        st <= st_n;
    end

    always_comb begin
        alarm_evt = (st == MATCH_ARMED) && !rearm && tick && match;
    end
endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_evt,
    input  logic         wr_clr,
    input  logic         wr_en,
    input  logic         wr_dis,
    input  logic [N-1:0] wbits,
    output logic [N-1:0] flags,
    output logic [N-1:0] mask,
    output logic         irq
);
    for (genvar i = 0; i < N; i++) begin : g_src
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                flags[i] <= 1'b0;
                mask[i]  <= 1'b0;
            end else begin
                if (set_evt[i])                flags[i] <= 1'b1;
                else if (wr_clr && wbits[i])   flags[i] <= 1'b0;
                if (wr_dis && wbits[i])        mask[i]  <= 1'b0;
                else if (wr_en && wbits[i])    mask[i]  <= 1'b1;
            end
        end
    end

    assign irq = |(flags & mask);
endmodule

// File: rtl/rtc_alarm_irq.sv
module rtc_alarm_irq
    import rtc_alarm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic [SEC_W-1:0]  cur_sec,
    input  logic [MIN_W-1:0]  cur_min,
    input  logic [HOUR_W-1:0] cur_hour,
    input  logic              cur_pm,
    input  logic [DAY_W-1:0]  cur_day,
    input  logic              upd_ack_evt,
    input  logic              sec_evt,
    input  logic              wr_alarm_time,
    input  logic              wr_alarm_day,
    input  logic              wr_status_clr,
    input  logic              wr_irq_en,
    input  logic              wr_irq_dis,
    input  logic [DATA_W-1:0] wdata,
    output logic [NSRC-1:0]   status,
    output logic [NSRC-1:0]   irq_mask,
    output logic              irq,
    output logic [DATA_W-1:0] alarm_time_rd,
    output logic [DATA_W-1:0] alarm_day_rd
);
    talarm_t         ta;
    dalarm_t         da;
    logic            alarm_evt;
    logic [NSRC-1:0] set_evt;

    alarm_regs u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_time(wr_alarm_time), .wr_day(wr_alarm_day),
        .wdata(wdata), .ta(ta), .da(da)
    );

    alarm_match u_match (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .rearm(wr_alarm_time | wr_alarm_day),
        .cur_sec(cur_sec), .cur_min(cur_min), .cur_hour(cur_hour),
        .cur_pm(cur_pm), .cur_day(cur_day),
        .ta(ta), .da(da), .alarm_evt(alarm_evt)
    );

    always_comb begin
        set_evt          = '0;
        set_evt[SRC_ACK] = upd_ack_evt;
        set_evt[SRC_ALM] = alarm_evt;
        set_evt[SRC_SEC] = sec_evt;
    end

    irq_ctrl #(.N(NSRC)) u_irq (
        .clk(clk), .rst_n(rst_n), .set_evt(set_evt),
        .wr_clr(wr_status_clr), .wr_en(wr_irq_en), .wr_dis(wr_irq_dis),
        .wbits(wdata[NSRC-1:0]),
        .flags(status), .mask(irq_mask), .irq(irq)
    );

    always_comb begin
        alarm_time_rd = '0;
        alarm_time_rd[TWORD_W-1:0] = ta;
        alarm_day_rd = '0;
        alarm_day_rd[DAY_EN_B] = da.day_en;
        alarm_day_rd[DAY_LSB +: DAY_W] = da.day;
    end
endmodule

// File: rtl/rtc_alarm_irq_chk.sv
module rtc_alarm_irq_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        tick,
    input logic        upd_ack_evt,
    input logic        sec_evt,
    input logic        wr_status_clr,
    input logic        wr_irq_dis,
    input logic [31:0] wdata,
    input logic [2:0]  status,
    input logic [2:0]  irq_mask,
    input logic        irq
);
    a_r6_alarm_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status[1]) |-> $past(tick));

    a_r8_alarm_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(status[1]) |-> $past(wr_status_clr && wdata[1]));

    a_r8_ack_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_status_clr && wdata[0] && !upd_ack_evt) |=> !status[0]);

    a_r9_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
        sec_evt |=> status[2]);

    a_r10_disable_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_irq_dis && wdata[2]) |=> !irq_mask[2]);

    a_r11_no_irq_unmasked: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_mask == 3'b000) |-> !irq);
endmodule

bind rtc_alarm_irq rtc_alarm_irq_chk u_chk (
    .clk(clk), .rst_n(rst_n), .tick(tick), .upd_ack_evt(upd_ack_evt),
    .sec_evt(sec_evt), .wr_status_clr(wr_status_clr), .wr_irq_dis(wr_irq_dis),
    .wdata(wdata), .status(status), .irq_mask(irq_mask), .irq(irq)
);

// File: tb/rtc_alarm_irq_bench.sv
module rtc_alarm_irq_bench;
    logic clk = 0, rst_n = 0, tick = 0;
    logic [6:0] cur_sec = 0, cur_min = 0;
    logic [5:0] cur_hour = 0;
    logic cur_pm = 0;
    logic [2:0] cur_day = 0;
    logic upd_ack_evt = 0, sec_evt = 0;
    logic wr_alarm_time = 0, wr_alarm_day = 0, wr_status_clr = 0, wr_irq_en = 0, wr_irq_dis = 0;
    logic [31:0] wdata = 0;
    logic [2:0] status, irq_mask;
    logic irq;
    logic [31:0] alarm_time_rd, alarm_day_rd;
    int n_chk = 0, n_fail = 0;

    always #5 clk = ~clk;

    rtc_alarm_irq u_rtc_alarm_irq (.*);

    task automatic cyc();
        @(negedge clk);
    endtask

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(ref logic strobe, input logic [31:0] d);
        strobe = 1; wdata = d; cyc(); strobe = 0; wdata = 0;
    endtask

    task automatic set_now(logic [5:0] h, logic pm, logic [6:0] m, logic [6:0] s, logic [2:0] d);
        cur_hour = h; cur_pm = pm; cur_min = m; cur_sec = s; cur_day = d;
        tick = 1; cyc(); tick = 0;
    endtask

    task automatic t_reset();
        chk("R1 status", 32'(status), 0);
        chk("R1 mask", 32'(irq_mask), 0);
        chk("R1 irq", 32'(irq), 0);
        chk("R1 time word", alarm_time_rd, 0);
        chk("R1 day word", alarm_day_rd, 32'h100);
    endtask

    task automatic t_readback();
        wr(wr_alarm_time, 32'hFFFF_FFFF);
        wr(wr_alarm_day, 32'hFFFF_FFFF);
        chk("R2 time layout", alarm_time_rd, 32'h00FF_FFFF);
        chk("R2 day layout", alarm_day_rd, 32'h0000_8700);
        wr(wr_alarm_time, 0);
        wr(wr_alarm_day, 0);
    endtask

    task automatic t_full_match();
        wr(wr_alarm_time, 32'h00C9_95B0);   // 09 PM : 15 : 30, all enabled
        wr(wr_alarm_day, 32'h0000_8300);    // day 3 enabled
        set_now(6'h09, 0, 7'h15, 7'h30, 3);
        chk("R3 AM vs PM no match", 32'(status[1]), 0);
        set_now(6'h09, 1, 7'h15, 7'h30, 4);
        chk("R3 wrong day no match", 32'(status[1]), 0);
        set_now(6'h09, 1, 7'h15, 7'h30, 3);
        chk("R3 full match", 32'(status[1]), 1);
        wr(wr_status_clr, 32'h2);
    endtask

    task automatic t_held();
        set_now(6'h09, 1, 7'h15, 7'h30, 3);
        chk("R6 held match silent", 32'(status[1]), 0);
        set_now(6'h09, 1, 7'h15, 7'h31, 3);
        set_now(6'h09, 1, 7'h15, 7'h30, 3);
        chk("R6 refire after release", 32'(status[1]), 1);
        wr(wr_status_clr, 32'h2);
    endtask

    task automatic t_rearm();
        wr(wr_alarm_time, 32'h00C9_95B0);
        set_now(6'h09, 1, 7'h15, 7'h30, 3);
        chk("R7 rearm by write", 32'(status[1]), 1);
        wr(wr_status_clr, 32'h2);
    endtask

    task automatic t_sec_only();
        wr(wr_alarm_time, 32'h0000_0085);
        wr(wr_alarm_day, 0);
        set_now(6'h02, 0, 7'h10, 7'h05, 1);
        chk("R4 seconds only first", 32'(status[1]), 1);
        wr(wr_status_clr, 32'h2);
        set_now(6'h02, 0, 7'h10, 7'h06, 1);
        chk("R4 other second", 32'(status[1]), 0);
        set_now(6'h03, 1, 7'h11, 7'h05, 6);
        chk("R4 next minute", 32'(status[1]), 1);
        wr(wr_status_clr, 32'h2);
    endtask

    task automatic t_none();
        wr(wr_alarm_time, 0);
        wr(wr_alarm_day, 0);
        set_now(6'h00, 0, 7'h00, 7'h00, 0);
        chk("R5 nothing enabled", 32'(status[1]), 0);
    endtask

    task automatic t_status();
        upd_ack_evt = 1; sec_evt = 1; cyc(); upd_ack_evt = 0; sec_evt = 0;
        chk("R8 flags set", 32'(status), 32'h5);
        wr(wr_status_clr, 0);
        chk("R8 zero clear", 32'(status), 32'h5);
        wr(wr_status_clr, 32'h1);
        chk("R8 clear ack", 32'(status), 32'h4);
        wr(wr_status_clr, 32'h4);
        chk("R8 clear sec", 32'(status), 0);
    endtask

    task automatic t_race();
        sec_evt = 1; cyc();
        wr_status_clr = 1; wdata = 32'h4; cyc();
        wr_status_clr = 0; wdata = 0; sec_evt = 0;
        chk("R9 event beats clear", 32'(status[2]), 1);
        wr(wr_status_clr, 32'h4);
    endtask

    task automatic t_mask();
        wr(wr_irq_en, 32'h3);
        chk("R10 enable", 32'(irq_mask), 32'h3);
        wr(wr_irq_en, 0);
        chk("R10 zero enable", 32'(irq_mask), 32'h3);
        wr(wr_irq_dis, 32'h1);
        chk("R10 disable", 32'(irq_mask), 32'h2);
        wr_irq_en = 1; wr_irq_dis = 1; wdata = 32'h4; cyc();
        wr_irq_en = 0; wr_irq_dis = 0; wdata = 0;
        chk("R10 disable beats enable", 32'(irq_mask), 32'h2);
        wr(wr_irq_dis, 32'h2);
        chk("R10 all off", 32'(irq_mask), 0);
    endtask

    task automatic t_irq();
        sec_evt = 1; cyc(); sec_evt = 0;
        chk("R11 unmasked flag", 32'(irq), 0);
        wr(wr_irq_en, 32'h2);
        chk("R11 other mask", 32'(irq), 0);
        wr(wr_irq_en, 32'h4);
        chk("R11 masked flag", 32'(irq), 1);
        wr(wr_irq_dis, 32'h4);
        chk("R11 mask removed", 32'(irq), 0);
        wr(wr_irq_en, 32'h4);
        wr(wr_status_clr, 32'h4);
        chk("R11 flag cleared", 32'(irq), 0);
        wr(wr_irq_dis, 32'h7);
    endtask

    initial begin
        fork
            begin
                cyc(); cyc(); rst_n = 1; cyc();
                t_reset(); t_readback(); t_full_match(); t_held(); t_rearm();
                t_sec_only(); t_none(); t_status(); t_race(); t_mask(); t_irq();
            end
            begin
                repeat (20000) @(posedge clk);
                n_chk++; n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule